// File: doc/BRIEF.md
# Rotate and Mask Unit

This block is the shifter slice of an integer execution pipe for rotate-with-mask operations. It takes a source operand, a rotate amount and a pair of mask bounds, and produces three registered results: the rotated operand, the generated mask, and the bitwise AND of the two. Merging into a destination register, flag updates and decode are handled elsewhere.

Bit positions in the mask bounds count from the most significant end: position 0 is the top bit. When the begin bound is larger than the end bound, the mask wraps around the word. A word-mode select turns the unit into a 32-bit rotator. It copies the low half of the source into the upper half before rotating, and it moves both mask bounds into the lower half of the word.

One cycle after `valid_i` is high at a clock edge, the results and `valid_o` are presented. When `valid_i` is low, the result registers keep their previous contents.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `rot_o`, `mask_o` and `res_o` are all zero.
- R2: `valid_o` equals the value `valid_i` had at the previous rising clock edge. Results for an operation sampled at edge k appear after edge k.
- R3: At an edge where `valid_i` is low, `rot_o`, `mask_o` and `res_o` keep their previous values.
- R4: When `word_mode_i`=0, `rot_o` is `src_i` rotated left by `amt_i` (0..63). An amount of 0 returns `src_i` unchanged. Example: 0xdeadbeef12345678 rotated by 10 gives 0xb6fbbc48d159e37a, and rotated by 35 gives 0x91a2b3c6f56df778.
- R5: When `word_mode_i`=1, `src_i[31:0]` fills both halves of the operand, which is then rotated left by `amt_i[4:0]`. `amt_i[5]` and `src_i[63:32]` have no effect.
- R6: When the effective begin is at most the effective end, `mask_o` has ones at the MSB-first positions begin through end inclusive and zeros elsewhere. MSB-first position p is bit 63-p. Examples: (37,63) gives 0x7ffffff and (0,37) gives 0xfffffffffc000000.
- R7: When the effective begin is greater than the effective end, `mask_o` is all ones except at positions end+1 through begin-1.
- R8: When `word_mode_i`=1, the effective bounds are `mb_i[4:0]`+32 and `me_i[4:0]`+32. Examples: (15,5) gives 0xfffffffffc01ffff and (0,0) gives 0x80000000. If the effective begin is at most the effective end, bits 63:32 of the mask are zero.
- R9: `res_o` equals `rot_o & mask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| src_i | input | 64 | Source operand |
| amt_i | input | 6 | Left rotate amount |
| word_mode_i | input | 1 | 1 selects 32-bit rotate and word-relative bounds |
| mb_i | input | 6 | Mask begin bound, counted from the MSB |
| me_i | input | 6 | Mask end bound, counted from the MSB |
| valid_o | output | 1 | Results valid |
| rot_o | output | 64 | Rotated operand |
| mask_o | output | 64 | Generated mask |
| res_o | output | 64 | Rotated operand ANDed with mask |

## Verification
The bench uses the default width of 64, so the amount and bound fields are six bits wide and the word half is 32 bits. At this width, every rotate amount from 0 to 63 can be swept exhaustively in both modes. The fixed example vectors can be compared exactly. The wrap boundaries can all be reached, including begin equal to end and begin one above end, which gives an all-ones mask.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int unsigned DEF_XLEN = 64;

  typedef enum logic {
    MODE_DWORD = 1'b0,
    MODE_WORD  = 1'b1
  } rot_mode_e;
endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] stage [SH_W+1];

  assign stage[0] = data_i;

  // log-depth barrel: stage s rotates left by 2**s when amt bit s set
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ?
        {stage[s][XLEN-STEP-1:0], stage[s][XLEN-1:XLEN-STEP]} : stage[s];
  end

  assign data_o = stage[SH_W];
endmodule

// File: rtl/rotmask_mask_gen.sv
module rotmask_mask_gen #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned SH_W = $clog2(XLEN)
) (
  input  logic [SH_W-1:0] begin_i,
  input  logic [SH_W-1:0] end_i,
  output logic [XLEN-1:0] mask_o
);
  logic wrap;
  assign wrap = begin_i > end_i;

  // position p counts from the MSB; it maps to bit XLEN-1-p
  for (genvar p = 0; p < XLEN; p++) begin : g_pos
    localparam logic [SH_W-1:0] POS = SH_W'(p);
    logic ge_b, le_e;
    assign ge_b = POS >= begin_i;
    assign le_e = POS <= end_i;
    assign mask_o[XLEN-1-p] = wrap ? (ge_b | le_e) : (ge_b & le_e);
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int unsigned XLEN = DEF_XLEN,
  localparam int unsigned SH_W = $clog2(XLEN),
  localparam int unsigned HALF = XLEN / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            word_mode_i,
  input  logic [SH_W-1:0] mb_i,
  input  logic [SH_W-1:0] me_i,
  output logic            valid_o,
  output logic [XLEN-1:0] rot_o,
  output logic [XLEN-1:0] mask_o,
  output logic [XLEN-1:0] res_o
);
  rot_mode_e       mode;
  logic [XLEN-1:0] rot_src, rot_val, mask_val;
  logic [SH_W-1:0] rot_amt, eff_b, eff_e;

  assign mode = rot_mode_e'(word_mode_i);

  always_comb begin
    if (mode == MODE_WORD) begin
      rot_src = {src_i[HALF-1:0], src_i[HALF-1:0]};
      rot_amt = {1'b0, amt_i[SH_W-2:0]};
      eff_b   = {1'b1, mb_i[SH_W-2:0]};
      eff_e   = {1'b1, me_i[SH_W-2:0]};
    end else begin
      rot_src = src_i;
      rot_amt = amt_i;
      eff_b   = mb_i;
      eff_e   = me_i;
    end
  end

  rotmask_rotator #(.XLEN(XLEN)) u_rot (
    .data_i (rot_src),
    .amt_i  (rot_amt),
    .data_o (rot_val)
  );

  rotmask_mask_gen #(.XLEN(XLEN)) u_mask (
    .begin_i (eff_b),
    .end_i   (eff_e),
    .mask_o  (mask_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rot_o   <= '0;
      mask_o  <= '0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        rot_o  <= rot_val;
        mask_o <= mask_val;
        res_o  <= rot_val & mask_val;
      end
    end
  end
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned SH_W = $clog2(XLEN),
  localparam int unsigned HALF = XLEN / 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [XLEN-1:0] src_i,
  input logic [SH_W-1:0] amt_i,
  input logic            word_mode_i,
  input logic [SH_W-1:0] mb_i,
  input logic [SH_W-1:0] me_i,
  input logic            valid_o,
  input logic [XLEN-1:0] rot_o,
  input logic [XLEN-1:0] mask_o,
  input logic [XLEN-1:0] res_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (!valid_o && rot_o == '0 && mask_o == '0 && res_o == '0);
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> valid_o == $past(valid_i));

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(valid_i)) |-> ($stable(rot_o) && $stable(mask_o) && $stable(res_o)));

  p_zero_amt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && !word_mode_i && amt_i == '0)) |-> rot_o == $past(src_i));

  p_word_halves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && word_mode_i)) |-> rot_o[XLEN-1:HALF] == rot_o[HALF-1:0]);

  p_word_mask_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(valid_i && word_mode_i && mb_i[SH_W-2:0] <= me_i[SH_W-2:0]))
      |-> mask_o[XLEN-1:HALF] == '0);

  p_and_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> res_o == (rot_o & mask_o));
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rotmask_unit_tb.sv
`timescale 1ns/1ps
module rotmask_unit_tb;
  localparam int XLEN = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] src_i = '0;
  logic [5:0]  amt_i = '0;
  logic        word_mode_i = 1'b0;
  logic [5:0]  mb_i = '0;
  logic [5:0]  me_i = '0;
  logic        valid_o;
  logic [63:0] rot_o, mask_o, res_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  rotmask_unit #(.XLEN(XLEN)) u_dut (.*);

  function automatic logic [63:0] ref_rot(logic [63:0] s, logic [5:0] a, logic wm);
    logic [63:0] v, r;
    int n;
    v = wm ? {s[31:0], s[31:0]} : s;
    n = wm ? int'(a[4:0]) : int'(a);
    for (int i = 0; i < 64; i++) r[(i + n) % 64] = v[i];
    return r;
  endfunction

  function automatic logic [63:0] ref_mask(logic [5:0] b, logic [5:0] e, logic wm);
    logic [63:0] m;
    int bb, ee;
    bb = wm ? int'(b[4:0]) + 32 : int'(b);
    ee = wm ? int'(e[4:0]) + 32 : int'(e);
    for (int p = 0; p < 64; p++)
      m[63-p] = (bb <= ee) ? (p >= bb && p <= ee) : (p >= bb || p <= ee);
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1ns after the capturing edge
  task automatic op(logic [63:0] s, logic [5:0] a, logic wm, logic [5:0] b, logic [5:0] e);
    @(negedge clk_i);
    valid_i = 1'b1; src_i = s; amt_i = a; word_mode_i = wm; mb_i = b; me_i = e;
    @(posedge clk_i); #1;
    valid_i = 1'b0;
  endtask

  task automatic op_full(string req, logic [63:0] s, logic [5:0] a, logic wm,
                         logic [5:0] b, logic [5:0] e);
    logic [63:0] er, em;
    op(s, a, wm, b, e);
    er = ref_rot(s, a, wm);
    em = ref_mask(b, e, wm);
    chk({req, " rot"}, rot_o, er);
    chk({req, " mask"}, mask_o, em);
    chk("R9 res", res_o, er & em);
    chk("R2 valid", {63'd0, valid_o}, 64'd1);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 valid", {63'd0, valid_o}, 64'd0);
    chk("R1 rot", rot_o, 64'd0);
    chk("R1 mask", mask_o, 64'd0);
    chk("R1 res", res_o, 64'd0);
  endtask

  task automatic t_rot64;
    op(64'hdeadbeef12345678, 6'd10, 1'b0, 6'd0, 6'd63);
    chk("R4 vec10", rot_o, 64'hb6fbbc48d159e37a);
    op(64'hdeadbeef12345678, 6'd35, 1'b0, 6'd0, 6'd63);
    chk("R4 vec35", rot_o, 64'h91a2b3c6f56df778);
    op(64'hdeadbeef12345678, 6'd0, 1'b0, 6'd0, 6'd63);
    chk("R4 zero", rot_o, 64'hdeadbeef12345678);
    for (int a = 0; a < 64; a++)
      op_full("R4 sweep", 64'h0123456789abcdef ^ (64'(a) << 40), 6'(a), 1'b0, 6'(a), 6'(63 - a));
  endtask

  task automatic t_rot32;
    for (int a = 0; a < 64; a++)
      op_full("R5 sweep", 64'h5a5a_0000_deadbeef | (64'(a) << 48), 6'(a), 1'b1, 6'd0, 6'd31);
    op(64'hffff_ffff_0000_0001, 6'd33, 1'b1, 6'd0, 6'd31);
    chk("R5 ignore high", rot_o, 64'h0000_0002_0000_0002);
  endtask

  task automatic t_mask_plain;
    op(64'd0, 6'd0, 1'b0, 6'd37, 6'd63);
    chk("R6 37..63", mask_o, 64'h0000_0000_07ff_ffff);
    op(64'd0, 6'd0, 1'b0, 6'd0, 6'd37);
    chk("R6 0..37", mask_o, 64'hffff_ffff_fc00_0000);
    op(64'd0, 6'd0, 1'b0, 6'd20, 6'd20);
    chk("R6 single", mask_o, 64'h0000_0800_0000_0000);
  endtask

  task automatic t_mask_wrap;
    op(64'd0, 6'd0, 1'b0, 6'd47, 6'd37);
    chk("R7 47/37", mask_o, 64'hffff_ffff_fc01_ffff);
    op(64'd0, 6'd0, 1'b0, 6'd21, 6'd20);
    chk("R7 all ones", mask_o, 64'hffff_ffff_ffff_ffff);
    op(64'd0, 6'd0, 1'b0, 6'd63, 6'd0);
    chk("R7 ends", mask_o, 64'h8000_0000_0000_0001);
    for (int b = 0; b < 64; b += 7)
      for (int e = 0; e < 64; e += 5)
        op_full("R7 grid", 64'hfedcba9876543210, 6'(b + e), 1'b0, 6'(b), 6'(e));
  endtask

  task automatic t_mask_word;
    op(64'd0, 6'd0, 1'b1, 6'd15, 6'd5);
    chk("R8 15/5", mask_o, 64'hffff_ffff_fc01_ffff);
    op(64'd0, 6'd0, 1'b1, 6'd0, 6'd0);
    chk("R8 0/0", mask_o, 64'h0000_0000_8000_0000);
    op(64'd0, 6'd0, 1'b1, 6'd32, 6'd33);
    chk("R8 high bits ignored", mask_o, 64'h0000_0000_c000_0000);
    op_full("R8 mix", 64'h0000_0000_1234_5678, 6'd7, 1'b1, 6'd3, 6'd28);
  endtask

  task automatic t_hold;
    logic [63:0] r, m, q;
    op(64'h1111_2222_3333_4444, 6'd4, 1'b0, 6'd8, 6'd50);
    r = rot_o; m = mask_o; q = res_o;
    @(negedge clk_i);
    src_i = 64'hffff_ffff_ffff_ffff; amt_i = 6'd9; mb_i = 6'd60; me_i = 6'd2;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R3 rot", rot_o, r);
    chk("R3 mask", mask_o, m);
    chk("R3 res", res_o, q);
    chk("R2 idle", {63'd0, valid_o}, 64'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk_i);
        t_reset();
        @(negedge clk_i) rst_ni = 1'b1;
        t_rot64();
        t_rot32();
        t_mask_plain();
        t_mask_wrap();
        t_mask_word();
        t_hold();
        #2 rst_ni = 1'b0;
        @(posedge clk_i);
        t_reset();
      end
      begin
        repeat (50000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule